// File: doc/BRIEF.md
# Cascadable Crossbar Routing Stage

This block is the routing and connection core of a small crossbar for a parallel point-to-point link. It has eight simplex inputs and eight simplex outputs; an input and an output of the same index can be paired to form one of four full-duplex channels. An upstream sender raises its request line while it holds a 32-bit routing word on its data lines. The stage takes the output port number from the low field of that word and arbitrates for the output. If it wins, it forwards the request with a rewritten routing word. It then relays the downstream connect answer back to the sender and, once connected, passes data words straight through.

To let stages be chained, the rewrite drops the port field that this stage has consumed and moves the rest of the 24-bit routing field down by four bits. It then writes this stage's own 4-bit identifier into the freed top nibble. A receiver at the end of a chain can read back the path from the identifiers that pile up in the word. A mode input turns the rewrite off, and the word is then forwarded as received.

Top module: `xbar_route_stage`

## Requirements
- R1: One clock edge after an idle input is sampled with its request high, and the low 4 bits of its word name a free port below 8, that output's request goes high. Every other output's request stays as it was.
- R2: With rewriting enabled, the forwarded word is {word[31:24], self_id, word[23:4]}. That is, the port nibble is dropped, bits 23..4 move down to bits 19..0, and the stage identifier fills bits 23..20.
- R3: With keep_word high, the forwarded word equals the received routing word bit for bit.
- R4: Bits 31..24 of the routing word reach the output unchanged in both modes.
- R5: A port value of 8 or more forwards no request on any output. No connect is returned for it, even if every downstream connect is high, until the input drops its request.
- R6: A request for an output already owned by another input is rejected. It gets no connect and no forwarded request, even after the owner releases, until the rejected input drops its request.
- R7: When several idle inputs request the same free output in the same cycle, the lowest-numbered input wins. The others are rejected, and each output has at most one owner.
- R8: While an input owns an output, conn_out of that input equals that output's conn_in one edge earlier.
- R9: From the edge where the owning output's conn_in is first sampled high, data_out of that output carries the owner's data_in with one edge of latency.
- R10: One edge after the owning input drops its request, the output's request and data go low and the output is free for a new request.
- R11: During reset all req_out, conn_out and data_out bits are zero.
- R12: A conn_in on an output that no input owns leaves every conn_out low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| self_id | input | 4 | Identifier written into the routing word by this stage |
| keep_word | input | 1 | 1: forward routing word unchanged; 0: rewrite it |
| req_in | input | 8 | Request from each upstream sender |
| data_in | input | 8x32 | Routing word, then data, from each sender |
| conn_out | output | 8 | Connect answer returned to each sender |
| req_out | output | 8 | Request forwarded on each output |
| data_out | output | 8x32 | Forwarded routing word, then data, per output |
| conn_in | input | 8 | Connect answer from the downstream side of each output |

## Verification
The hardest situation to reach is a contested output. Either two inputs must request it on exactly the same edge, or a second input must request it while it is held, and the loser must then be seen to stay disconnected after the owner leaves. The stimulus raises two requests together on one edge with distinct routing words, so the forwarded word shows which input won. It then holds a rejected request across the owner's release to show that the rejection is sticky. A table of routing words drives each output through both modes and through port values that are out of range.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int WORD_W  = 32;  // data and routing word width
  localparam int ROUTE_W = 24;  // bits taking part in routing
  localparam int FIELD_W = 4;   // port / identifier field width

  typedef enum logic [1:0] {IN_IDLE, IN_OWN, IN_REJ} in_state_e;

  // drop consumed port nibble, shift route field down, insert own identifier
  function automatic logic [WORD_W-1:0] route_shift(
    input logic [WORD_W-1:0]  w,
    input logic [FIELD_W-1:0] self_tag
  );
    return {w[WORD_W-1:ROUTE_W], self_tag, w[ROUTE_W-1:FIELD_W]};
  endfunction
endpackage

// File: rtl/xbar_route_decode.sv
module xbar_route_decode
  import xbar_pkg::*;
#(
  parameter int N_PORTS = 8
) (
  input  logic [WORD_W-1:0]  route_word,
  input  logic               keep_word,
  input  logic [FIELD_W-1:0] self_id,
  output logic [FIELD_W-1:0] port,
  output logic               in_range,
  output logic [WORD_W-1:0]  fwd_word
);
  always_comb begin
    port     = route_word[FIELD_W-1:0];
    in_range = (int'(port) < N_PORTS);
    fwd_word = keep_word ? route_word : route_shift(route_word, self_id);
  end
endmodule

// File: rtl/xbar_port_arb.sv
module xbar_port_arb #(
  parameter int N_PORTS = 8,
  localparam int SEL_W = $clog2(N_PORTS)
) (
  input  logic [N_PORTS-1:0] want,
  input  logic               busy,
  output logic [N_PORTS-1:0] grant,
  output logic [SEL_W-1:0]   grant_idx,
  output logic               grant_any
);
  // scan downward so the lowest requesting index is the last to be kept
  always_comb begin
    grant     = '0;
    grant_idx = '0;
    grant_any = 1'b0;
    if (!busy) begin
      for (int k = N_PORTS - 1; k >= 0; k--) begin
        if (want[k]) begin
          grant     = '0;
          grant[k]  = 1'b1;
          grant_idx = SEL_W'(k);
          grant_any = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xbar_out_port.sv
module xbar_out_port
  import xbar_pkg::*;
#(
  parameter int N_PORTS = 8,
  localparam int SEL_W = $clog2(N_PORTS)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            grant_any,
  input  logic [SEL_W-1:0]                grant_idx,
  input  logic [N_PORTS-1:0][WORD_W-1:0]  fwd_words,
  input  logic [N_PORTS-1:0][WORD_W-1:0]  data_in,
  input  logic [N_PORTS-1:0]              req_in,
  input  logic                            conn_in,
  output logic                            busy,
  output logic [SEL_W-1:0]                owner,
  output logic                            req_out,
  output logic [WORD_W-1:0]               data_out
);
  logic linked;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      owner    <= '0;
      linked   <= 1'b0;
      req_out  <= 1'b0;
      data_out <= '0;
    end else if (grant_any) begin
      busy     <= 1'b1;
      owner    <= grant_idx;
      linked   <= 1'b0;
      req_out  <= 1'b1;
      data_out <= fwd_words[grant_idx];
    end else if (busy && !req_in[owner]) begin
      busy     <= 1'b0;
      linked   <= 1'b0;
      req_out  <= 1'b0;
      data_out <= '0;
    end else if (busy && (linked || conn_in)) begin
      linked   <= 1'b1;
      data_out <= data_in[owner];
    end
  end

  // R10: owner leaving frees the output on the next edge
  assert_release_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && !grant_any && !req_in[owner]) |=> (!req_out && !busy));

  // R9: once linked, output data follows the owner's input
  assert_pass_data_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && req_in[owner] && conn_in) |=> (data_out == $past(data_in[owner])));
endmodule

// File: rtl/xbar_route_stage.sv
module xbar_route_stage
  import xbar_pkg::*;
#(
  parameter int N_PORTS = 8,
  localparam int SEL_W = $clog2(N_PORTS)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [FIELD_W-1:0]             self_id,
  input  logic                           keep_word,
  input  logic [N_PORTS-1:0]             req_in,
  input  logic [N_PORTS-1:0][WORD_W-1:0] data_in,
  output logic [N_PORTS-1:0]             conn_out,
  output logic [N_PORTS-1:0]             req_out,
  output logic [N_PORTS-1:0][WORD_W-1:0] data_out,
  input  logic [N_PORTS-1:0]             conn_in
);
  logic [N_PORTS-1:0][FIELD_W-1:0] port_w;
  logic [N_PORTS-1:0]              ok_w;
  logic [N_PORTS-1:0][WORD_W-1:0]  fwd_w;
  logic [N_PORTS-1:0]              fresh;
  logic [N_PORTS-1:0]              granted;
  logic [N_PORTS-1:0]              busy_of;
  logic [N_PORTS-1:0][N_PORTS-1:0] want;    // [output][input]
  logic [N_PORTS-1:0][N_PORTS-1:0] grant;   // [output][input]
  logic [N_PORTS-1:0][N_PORTS-1:0] owned;   // [input][output]
  logic [N_PORTS-1:0][SEL_W-1:0]   grant_idx;
  logic [N_PORTS-1:0]              grant_any;
  logic [N_PORTS-1:0]              busy;
  logic [N_PORTS-1:0][SEL_W-1:0]   owner;
  in_state_e                       st    [N_PORTS];
  logic [SEL_W-1:0]                sel_q [N_PORTS];

  // per-input routing word decode and rewrite
  for (genvar i = 0; i < N_PORTS; i++) begin : g_dec
    xbar_route_decode #(.N_PORTS(N_PORTS)) u_dec (
      .route_word (data_in[i]),
      .keep_word  (keep_word),
      .self_id    (self_id),
      .port       (port_w[i]),
      .in_range   (ok_w[i]),
      .fwd_word   (fwd_w[i])
    );
  end

  always_comb begin
    for (int i = 0; i < N_PORTS; i++) begin
      fresh[i]   = req_in[i] && (st[i] == IN_IDLE);
      busy_of[i] = ok_w[i] && busy[port_w[i][SEL_W-1:0]];
      granted[i] = 1'b0;
      for (int p = 0; p < N_PORTS; p++) begin
        want[p][i]  = fresh[i] && ok_w[i] && (port_w[i] == FIELD_W'(p));
        owned[i][p] = busy[p] && (owner[p] == SEL_W'(i));
      end
    end
    for (int p = 0; p < N_PORTS; p++)
      for (int i = 0; i < N_PORTS; i++)
        granted[i] = granted[i] | grant[p][i];
  end

  // per-output arbitration and connection state
  for (genvar p = 0; p < N_PORTS; p++) begin : g_out
    xbar_port_arb #(.N_PORTS(N_PORTS)) u_arb (
      .want      (want[p]),
      .busy      (busy[p]),
      .grant     (grant[p]),
      .grant_idx (grant_idx[p]),
      .grant_any (grant_any[p])
    );

    xbar_out_port #(.N_PORTS(N_PORTS)) u_port (
      .clk       (clk),
      .rst       (rst),
      .grant_any (grant_any[p]),
      .grant_idx (grant_idx[p]),
      .fwd_words (fwd_w),
      .data_in   (data_in),
      .req_in    (req_in),
      .conn_in   (conn_in[p]),
      .busy      (busy[p]),
      .owner     (owner[p]),
      .req_out   (req_out[p]),
      .data_out  (data_out[p])
    );

    // R7: at most one winner per output
    assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant[p]));
  end

  // per-input connection state and connect relay
  for (genvar i = 0; i < N_PORTS; i++) begin : g_in
    always_ff @(posedge clk) begin
      if (rst) begin
        st[i]       <= IN_IDLE;
        sel_q[i]    <= '0;
        conn_out[i] <= 1'b0;
      end else begin
        conn_out[i] <= (st[i] == IN_OWN) && req_in[i] && conn_in[sel_q[i]];
        unique case (st[i])
          IN_IDLE: if (req_in[i]) begin
            st[i]    <= granted[i] ? IN_OWN : IN_REJ;
            sel_q[i] <= port_w[i][SEL_W-1:0];
          end
          IN_OWN, IN_REJ: if (!req_in[i]) st[i] <= IN_IDLE;
          default: st[i] <= IN_IDLE;
        endcase
      end
    end

    // R5: a port number past the last output is rejected
    assert_bad_port_R5: assert property (@(posedge clk) disable iff (rst)
      (fresh[i] && !ok_w[i]) |=> (st[i] == IN_REJ));

    // R6: request for a held output is rejected
    assert_busy_reject_R6: assert property (@(posedge clk) disable iff (rst)
      (fresh[i] && busy_of[i]) |=> (st[i] == IN_REJ));

    // R7: an input never holds two outputs
    assert_one_owner_R7: assert property (@(posedge clk) disable iff (rst)
      $countones(owned[i]) <= 1);

    // R12: no connect reaches an input that holds nothing
    assert_no_stray_conn_R12: assert property (@(posedge clk) disable iff (rst)
      (st[i] != IN_OWN) |=> !conn_out[i]);
  end
endmodule

// File: tb/xbar_route_stage_test.sv
module xbar_route_stage_test;
  localparam int N = 8;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [3:0]           self_id = 4'hC;
  logic                 keep_word = 1'b0;
  logic [N-1:0]         req_in = '0;
  logic [N-1:0][31:0]   data_in = '0;
  logic [N-1:0]         conn_out;
  logic [N-1:0]         req_out;
  logic [N-1:0][31:0]   data_out;
  logic [N-1:0]         conn_in = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  xbar_route_stage #(.N_PORTS(N)) uut (
    .clk(clk), .rst(rst), .self_id(self_id), .keep_word(keep_word),
    .req_in(req_in), .data_in(data_in), .conn_out(conn_out),
    .req_out(req_out), .data_out(data_out), .conn_in(conn_in)
  );

  typedef struct packed {
    logic [2:0]  src;
    logic [31:0] word;
    logic        keep;
    logic        ok;
    logic [31:0] expw;
  } vec_t;

  // src, routing word, keep mode, port valid, expected forwarded word
  localparam vec_t VEC [7] = '{
    '{3'd0, 32'hA5123456, 1'b0, 1'b1, 32'hA5C12345},
    '{3'd3, 32'h00ABCDE2, 1'b0, 1'b1, 32'h00CABCDE},
    '{3'd7, 32'hFF000007, 1'b0, 1'b1, 32'hFFC00000},
    '{3'd5, 32'h3C987651, 1'b1, 1'b1, 32'h3C987651},
    '{3'd2, 32'h12345678, 1'b0, 1'b0, 32'h0},
    '{3'd1, 32'h0000000F, 1'b0, 1'b0, 32'h0},
    '{3'd4, 32'h5A000000, 1'b0, 1'b1, 32'h5AC00000}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    repeat (3) step();
    chk("R11 req_out", 64'(req_out), 64'h0);
    chk("R11 conn_out", 64'(conn_out), 64'h0);
    chk("R11 data_out", 64'(|data_out), 64'h0);
    rst = 1'b0;
    step();

    // table walk: routing, rewrite, keep mode, bad ports, connect, data, release
    foreach (VEC[n]) begin
      logic [3:0] prt;
      prt = VEC[n].word[3:0];
      keep_word = VEC[n].keep;
      data_in[VEC[n].src] = VEC[n].word;
      req_in[VEC[n].src] = 1'b1;
      step();
      if (VEC[n].ok) begin
        chk($sformatf("R1 req_out vec%0d", n), 64'(req_out), 64'(8'h1 << prt[2:0]));
        chk($sformatf("%s word vec%0d", VEC[n].keep ? "R3" : "R2/R4", n),
            64'(data_out[prt[2:0]]), 64'(VEC[n].expw));
        conn_in[prt[2:0]] = 1'b1;
        data_in[VEC[n].src] = 32'hDEAD0000 | n;
        step();
        chk($sformatf("R8 conn_out vec%0d", n), 64'(conn_out), 64'(8'h1 << VEC[n].src));
        chk($sformatf("R9 data vec%0d", n), 64'(data_out[prt[2:0]]), 64'(32'hDEAD0000 | n));
      end else begin
        chk($sformatf("R5 req_out vec%0d", n), 64'(req_out), 64'h0);
        conn_in = '1;
        step();
        chk($sformatf("R5 conn_out vec%0d", n), 64'(conn_out), 64'h0);
      end
      req_in = '0;
      conn_in = '0;
      step();
      chk($sformatf("R10 release vec%0d", n), 64'({req_out, conn_out}), 64'h0);
    end

    // R6: held output, sticky rejection
    keep_word = 1'b0;
    data_in[0] = 32'h00000003;
    req_in[0] = 1'b1;
    step();
    chk("R1 owner0 port3", 64'(req_out), 64'h08);
    data_in[1] = 32'h00000013;
    req_in[1] = 1'b1;
    step();
    chk("R6 word kept", 64'(data_out[3]), 64'h00C00000);
    conn_in[3] = 1'b1;
    step();
    chk("R6 conn only owner", 64'(conn_out), 64'h01);
    req_in[0] = 1'b0;
    step();
    chk("R10 freed", 64'(req_out), 64'h0);
    step();
    chk("R6 reject sticky", 64'({req_out, conn_out}), 64'h0);
    req_in[1] = 1'b0;
    conn_in = '0;
    step();
    req_in[1] = 1'b1;
    step();
    chk("R10 reuse req", 64'(req_out), 64'h08);
    chk("R10 reuse word", 64'(data_out[3]), 64'h00C00001);
    req_in = '0;
    step();

    // R7: same-edge contest, lowest index wins
    data_in[5] = 32'h00000054;
    data_in[2] = 32'h00000024;
    req_in[5] = 1'b1;
    req_in[2] = 1'b1;
    step();
    chk("R7 req_out", 64'(req_out), 64'h10);
    chk("R7 winner word", 64'(data_out[4]), 64'h00C00002);
    conn_in[4] = 1'b1;
    step();
    chk("R7 conn winner", 64'(conn_out), 64'h04);
    req_in = '0;
    conn_in = '0;
    step();

    // R12: connect on unowned outputs
    conn_in = '1;
    step();
    step();
    chk("R12 conn_out", 64'(conn_out), 64'h0);
    chk("R12 req_out", 64'(req_out), 64'h0);
    conn_in = '0;
    step();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule